// File: doc/BRIEF.md
# Radix-2 Complex Butterfly Unit

This block is the arithmetic core of a radix-2 decimation-in-time FFT stage. On each clock it accepts two complex operands A and B, a complex twiddle W and a qualifying strobe. It returns the pair X = A + W·B and Y = A − W·B, and raises its output strobe a fixed three cycles later. All real and imaginary words at the ports are signed Q1.15. The unit is fully pipelined, so a new operand set can enter on every cycle and gaps in the strobe are preserved.

Internally the four partial products of W·B are kept at full precision. They are combined and then rounded to nearest (a tie rounds upward) into an 18-bit intermediate. That intermediate is wide enough to hold the growth of both the product and the following add. The final add and subtract clip to the Q1.15 range instead of wrapping.

A 2-bit twiddle class input tells the unit when W is trivial. For W = 1 or W = −j the general multiplier is bypassed: its operands are forced to zero and W·B is formed by routing and negation. The twiddle source, address sequencing and any stage-to-stage scaling belong to the surrounding FFT engine.

Top module: `bfly_r2_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `out_vld` and all four result words to zero.
- R2: `out_vld` equals the value of `in_vld` sampled three rising edges earlier, so back-to-back strobes and gaps come out unchanged.
- R3: For class 2'b00 (general), W·B = (round((c·wr − d·wi)/2^15), round((c·wi + d·wr)/2^15)), where B = c + dj and W = wr + wi·j. A twiddle of zero therefore yields X = Y = A.
- R4: X = A + W·B and Y = A − W·B, computed separately on the real part and on the imaginary part, with W·B held at 18 bits of working width.
- R5: Each of the four result words saturates to 32767 when the exact sum is above it and to −32768 when the exact sum is below it.
- R6: For class 2'b01 (twiddle one), W·B = B exactly, and the `w_re`/`w_im` inputs have no effect on the outputs.
- R7: For class 2'b10 (twiddle −j), W·B = (d, −c) exactly, including c = −32768, where −c = +32768 is carried before the clip. The `w_re`/`w_im` inputs have no effect on the outputs.
- R8: Class 2'b11 behaves exactly like class 2'b00.
- R9: Rounding adds 2^14 to the product sum and then floors the division by 2^15, so a fraction of exactly one half rounds toward plus infinity (for example, 1·16384 gives 1 and −1·16384 gives 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand set valid |
| in_cls | input | 2 | Twiddle class: 00 general, 01 one, 10 minus-j, 11 general |
| a_re | input | 16 | Operand A real, Q1.15 |
| a_im | input | 16 | Operand A imaginary, Q1.15 |
| b_re | input | 16 | Operand B real, Q1.15 |
| b_im | input | 16 | Operand B imaginary, Q1.15 |
| w_re | input | 16 | Twiddle real, Q1.15 |
| w_im | input | 16 | Twiddle imaginary, Q1.15 |
| out_vld | output | 1 | Result valid, three cycles after `in_vld` |
| x_re | output | 16 | A + W·B real, saturated |
| x_im | output | 16 | A + W·B imaginary, saturated |
| y_re | output | 16 | A − W·B real, saturated |
| y_im | output | 16 | A − W·B imaginary, saturated |

## Verification
The bound properties assume that every input is a known value at each rising edge and that the operand set paired with a strobe is the one presented on that same edge. They look back exactly three edges, and they only do so after three edges have passed since reset was released. The bench changes all inputs only on falling edges and keeps them free of unknowns during and after reset. It drives real data even on cycles without a strobe, so any leak of invalid operands into the results would show. Its operands span the full signed range, including −32768 in every lane, so the saturation and negation corners lie within what the properties cover.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Twiddle class selecting the multiply path
    typedef enum logic [1:0] {
        TW_GEN  = 2'b00,
        TW_ONE  = 2'b01,
        TW_NEGJ = 2'b10,
        TW_GENX = 2'b11
    } tw_cls_e;

endpackage

// File: rtl/bfly_mul_stage.sv
// Stage 1: full-precision partial products of W*B, gated off for trivial twiddles.
module bfly_mul_stage
    import bfly_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  tw_cls_e                   in_cls,
    input  logic signed [DW-1:0]      a_re,
    input  logic signed [DW-1:0]      a_im,
    input  logic signed [DW-1:0]      b_re,
    input  logic signed [DW-1:0]      b_im,
    input  logic signed [TW-1:0]      w_re,
    input  logic signed [TW-1:0]      w_im,
    output logic                      s1_vld,
    output tw_cls_e                   s1_cls,
    output logic signed [DW-1:0]      s1_a_re,
    output logic signed [DW-1:0]      s1_a_im,
    output logic signed [DW-1:0]      s1_b_re,
    output logic signed [DW-1:0]      s1_b_im,
    output logic signed [DW+TW-1:0]   s1_p_cr,
    output logic signed [DW+TW-1:0]   s1_p_di,
    output logic signed [DW+TW-1:0]   s1_p_ci,
    output logic signed [DW+TW-1:0]   s1_p_dr
);
    localparam int PW = DW + TW;

    typedef struct packed {
        logic                 vld;
        tw_cls_e              cls;
        logic signed [DW-1:0] a_re;
        logic signed [DW-1:0] a_im;
        logic signed [DW-1:0] b_re;
        logic signed [DW-1:0] b_im;
        logic signed [PW-1:0] p_cr;
        logic signed [PW-1:0] p_di;
        logic signed [PW-1:0] p_ci;
        logic signed [PW-1:0] p_dr;
    } s1_t;

    s1_t s1_d, s1_q;

    logic                 use_mul;
    logic signed [PW-1:0] opc, opd, opwr, opwi;

    always_comb begin
        use_mul = (in_cls == TW_GEN) || (in_cls == TW_GENX);
        opc     = use_mul ? PW'(b_re) : '0;
        opd     = use_mul ? PW'(b_im) : '0;
        opwr    = use_mul ? PW'(w_re) : '0;
        opwi    = use_mul ? PW'(w_im) : '0;

        s1_d      = '0;
        s1_d.vld  = in_vld;
        s1_d.cls  = in_cls;
        s1_d.a_re = a_re;
        s1_d.a_im = a_im;
        s1_d.b_re = b_re;
        s1_d.b_im = b_im;
        s1_d.p_cr = opc * opwr;
        s1_d.p_di = opd * opwi;
        s1_d.p_ci = opc * opwi;
        s1_d.p_dr = opd * opwr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign s1_vld  = s1_q.vld;
    assign s1_cls  = s1_q.cls;
    assign s1_a_re = s1_q.a_re;
    assign s1_a_im = s1_q.a_im;
    assign s1_b_re = s1_q.b_re;
    assign s1_b_im = s1_q.b_im;
    assign s1_p_cr = s1_q.p_cr;
    assign s1_p_di = s1_q.p_di;
    assign s1_p_ci = s1_q.p_ci;
    assign s1_p_dr = s1_q.p_dr;

endmodule

// File: rtl/bfly_round_stage.sv
// Stage 2: combine partial products, round half up, or route a trivial twiddle.
module bfly_round_stage
    import bfly_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s1_vld,
    input  tw_cls_e                       s1_cls,
    input  logic signed [DW-1:0]          s1_a_re,
    input  logic signed [DW-1:0]          s1_a_im,
    input  logic signed [DW-1:0]          s1_b_re,
    input  logic signed [DW-1:0]          s1_b_im,
    input  logic signed [DW+TW-1:0]       s1_p_cr,
    input  logic signed [DW+TW-1:0]       s1_p_di,
    input  logic signed [DW+TW-1:0]       s1_p_ci,
    input  logic signed [DW+TW-1:0]       s1_p_dr,
    output logic                          s2_vld,
    output logic signed [DW-1:0]          s2_a_re,
    output logic signed [DW-1:0]          s2_a_im,
    output logic signed [DW+TW-TW+1:0]    s2_wb_re,
    output logic signed [DW+TW-TW+1:0]    s2_wb_im
);
    localparam int PW   = DW + TW;
    localparam int SW   = PW + 1;
    localparam int FRAC = TW - 1;
    localparam int MW   = SW - FRAC;
    localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);

    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] a_re;
        logic signed [DW-1:0] a_im;
        logic signed [MW-1:0] wb_re;
        logic signed [MW-1:0] wb_im;
    } s2_t;

    s2_t s2_d, s2_q;

    logic signed [SW-1:0] sum_re, sum_im, rnd_re, rnd_im;
    logic signed [MW-1:0] bx_re, bx_im;

    always_comb begin
        sum_re = SW'(s1_p_cr) - SW'(s1_p_di);
        sum_im = SW'(s1_p_ci) + SW'(s1_p_dr);
        rnd_re = sum_re + HALF;
        rnd_im = sum_im + HALF;
        bx_re  = MW'(s1_b_re);
        bx_im  = MW'(s1_b_im);

        s2_d      = '0;
        s2_d.vld  = s1_vld;
        s2_d.a_re = s1_a_re;
        s2_d.a_im = s1_a_im;
        case (s1_cls)
            TW_ONE: begin
                s2_d.wb_re = bx_re;
                s2_d.wb_im = bx_im;
            end
            TW_NEGJ: begin
                s2_d.wb_re = bx_im;
                s2_d.wb_im = -bx_re;
            end
            default: begin
                s2_d.wb_re = MW'(rnd_re >>> FRAC);
                s2_d.wb_im = MW'(rnd_im >>> FRAC);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign s2_vld   = s2_q.vld;
    assign s2_a_re  = s2_q.a_re;
    assign s2_a_im  = s2_q.a_im;
    assign s2_wb_re = s2_q.wb_re;
    assign s2_wb_im = s2_q.wb_im;

endmodule

// File: rtl/bfly_addsub_stage.sv
// Stage 3: sum and difference on each lane, clipped to the port width.
module bfly_addsub_stage #(
    parameter int DW = 16,
    parameter int MW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s2_vld,
    input  logic signed [DW-1:0] s2_a_re,
    input  logic signed [DW-1:0] s2_a_im,
    input  logic signed [MW-1:0] s2_wb_re,
    input  logic signed [MW-1:0] s2_wb_im,
    output logic                 out_vld,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int AW = MW + 1;
    localparam logic signed [AW-1:0] TOP = AW'((2 ** (DW - 1)) - 1);
    localparam logic signed [AW-1:0] BOT = ~TOP;

    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] x_re;
        logic signed [DW-1:0] x_im;
        logic signed [DW-1:0] y_re;
        logic signed [DW-1:0] y_im;
    } s3_t;

    s3_t s3_d, s3_q;

    function automatic logic signed [DW-1:0] clip(input logic signed [AW-1:0] v);
        if (v > TOP)      return TOP[DW-1:0];
        else if (v < BOT) return BOT[DW-1:0];
        else              return v[DW-1:0];
    endfunction

    logic signed [AW-1:0] sx_re, sx_im, sy_re, sy_im;

    always_comb begin
        sx_re = AW'(s2_a_re) + AW'(s2_wb_re);
        sx_im = AW'(s2_a_im) + AW'(s2_wb_im);
        sy_re = AW'(s2_a_re) - AW'(s2_wb_re);
        sy_im = AW'(s2_a_im) - AW'(s2_wb_im);

        s3_d      = '0;
        s3_d.vld  = s2_vld;
        s3_d.x_re = clip(sx_re);
        s3_d.x_im = clip(sx_im);
        s3_d.y_re = clip(sy_re);
        s3_d.y_im = clip(sy_im);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    assign out_vld = s3_q.vld;
    assign x_re    = s3_q.x_re;
    assign x_im    = s3_q.x_im;
    assign y_re    = s3_q.y_re;
    assign y_im    = s3_q.y_im;

endmodule

// File: rtl/bfly_r2_unit.sv
// Radix-2 DIT butterfly: X = A + W*B, Y = A - W*B, three-cycle pipeline.
module bfly_r2_unit
    import bfly_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [1:0]           in_cls,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 out_vld,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int PW = DW + TW;
    localparam int MW = DW + 2;

    logic                 s1_vld;
    tw_cls_e              s1_cls;
    logic signed [DW-1:0] s1_a_re, s1_a_im, s1_b_re, s1_b_im;
    logic signed [PW-1:0] s1_p_cr, s1_p_di, s1_p_ci, s1_p_dr;
    logic                 s2_vld;
    logic signed [DW-1:0] s2_a_re, s2_a_im;
    logic signed [MW-1:0] s2_wb_re, s2_wb_im;

    bfly_mul_stage #(.DW(DW), .TW(TW)) mul_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_cls  (tw_cls_e'(in_cls)),
        .a_re    (a_re),
        .a_im    (a_im),
        .b_re    (b_re),
        .b_im    (b_im),
        .w_re    (w_re),
        .w_im    (w_im),
        .s1_vld  (s1_vld),
        .s1_cls  (s1_cls),
        .s1_a_re (s1_a_re),
        .s1_a_im (s1_a_im),
        .s1_b_re (s1_b_re),
        .s1_b_im (s1_b_im),
        .s1_p_cr (s1_p_cr),
        .s1_p_di (s1_p_di),
        .s1_p_ci (s1_p_ci),
        .s1_p_dr (s1_p_dr)
    );

    bfly_round_stage #(.DW(DW), .TW(TW)) rnd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_vld   (s1_vld),
        .s1_cls   (s1_cls),
        .s1_a_re  (s1_a_re),
        .s1_a_im  (s1_a_im),
        .s1_b_re  (s1_b_re),
        .s1_b_im  (s1_b_im),
        .s1_p_cr  (s1_p_cr),
        .s1_p_di  (s1_p_di),
        .s1_p_ci  (s1_p_ci),
        .s1_p_dr  (s1_p_dr),
        .s2_vld   (s2_vld),
        .s2_a_re  (s2_a_re),
        .s2_a_im  (s2_a_im),
        .s2_wb_re (s2_wb_re),
        .s2_wb_im (s2_wb_im)
    );

    bfly_addsub_stage #(.DW(DW), .MW(MW)) sum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s2_vld   (s2_vld),
        .s2_a_re  (s2_a_re),
        .s2_a_im  (s2_a_im),
        .s2_wb_re (s2_wb_re),
        .s2_wb_im (s2_wb_im),
        .out_vld  (out_vld),
        .x_re     (x_re),
        .x_im     (x_im),
        .y_re     (y_re),
        .y_im     (y_im)
    );

endmodule

// File: rtl/bfly_r2_chk.sv
// Properties for bfly_r2_unit, attached by bind.
module bfly_r2_chk #(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_vld,
    input logic [1:0]           in_cls,
    input logic signed [DW-1:0] a_re,
    input logic signed [DW-1:0] a_im,
    input logic signed [DW-1:0] b_re,
    input logic signed [DW-1:0] b_im,
    input logic signed [TW-1:0] w_re,
    input logic signed [TW-1:0] w_im,
    input logic                 out_vld,
    input logic signed [DW-1:0] x_re,
    input logic signed [DW-1:0] x_im,
    input logic signed [DW-1:0] y_re,
    input logic signed [DW-1:0] y_im
);
    logic [1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)               seen_q <= 2'd0;
        else if (seen_q != 2'd3)  seen_q <= seen_q + 2'd1;
    end

    function automatic logic signed [DW-1:0] lim(input longint v);
        longint hi;
        hi = (longint'(1) <<< (DW - 1)) - 1;
        if (v > hi)        return DW'(hi);
        else if (v < -hi - 1) return DW'(-hi - 1);
        else               return DW'(v);
    endfunction

    // R2: strobe delayed by exactly three edges
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3) |-> (out_vld == $past(in_vld, 3)))
        else $error("R2 latency mismatch");

    // R3: zero twiddle on the general path returns A on both outputs
    assert_zero_tw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(in_vld, 3) && $past(in_cls, 3) == 2'b00
         && $past(w_re, 3) == '0 && $past(w_im, 3) == '0)
        |-> (x_re == $past(a_re, 3) && x_im == $past(a_im, 3)
             && y_re == $past(a_re, 3) && y_im == $past(a_im, 3)))
        else $error("R3 zero twiddle mismatch");

    // R6: twiddle one passes B to the add/subtract unchanged
    assert_one_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(in_vld, 3) && $past(in_cls, 3) == 2'b01)
        |-> (x_re == lim(longint'($past(a_re, 3)) + longint'($past(b_re, 3)))
             && x_im == lim(longint'($past(a_im, 3)) + longint'($past(b_im, 3)))
             && y_re == lim(longint'($past(a_re, 3)) - longint'($past(b_re, 3)))
             && y_im == lim(longint'($past(a_im, 3)) - longint'($past(b_im, 3)))))
        else $error("R6 one bypass mismatch");

    // R7: twiddle minus-j maps (c, d) to (d, -c)
    assert_negj_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(in_vld, 3) && $past(in_cls, 3) == 2'b10)
        |-> (x_re == lim(longint'($past(a_re, 3)) + longint'($past(b_im, 3)))
             && x_im == lim(longint'($past(a_im, 3)) - longint'($past(b_re, 3)))
             && y_re == lim(longint'($past(a_re, 3)) - longint'($past(b_im, 3)))
             && y_im == lim(longint'($past(a_im, 3)) + longint'($past(b_re, 3)))))
        else $error("R7 minus-j bypass mismatch");

endmodule

bind bfly_r2_unit bfly_r2_chk #(.DW(DW), .TW(TW)) chk_i (.*);

// File: tb/bfly_r2_unit_tb_top.sv
`timescale 1ns/1ps
module bfly_r2_unit_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n;
    logic               in_vld;
    logic [1:0]         in_cls;
    logic signed [15:0] a_re, a_im, b_re, b_im, w_re, w_im;
    logic               out_vld;
    logic signed [15:0] x_re, x_im, y_re, y_im;

    bfly_r2_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cls(in_cls),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im), .out_vld(out_vld),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
    );

    typedef struct {
        bit vld;
        int xr, xi, yr, yi;
        int tag;
    } exp_t;

    exp_t q[$];
    int   cur_tag = 4;
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   done = 0;

    function automatic string tname(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int clip16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int rhu(input longint p);
        return int'((p + 64'sd16384) >>> 15);
    endfunction

    // Behavioural reference: one entry per rising edge
    function automatic exp_t model();
        exp_t e;
        longint c, d, wr, wi, pr, pi;
        e.vld = 0; e.xr = 0; e.xi = 0; e.yr = 0; e.yi = 0; e.tag = 1;
        if (!rst_n) return e;
        e.vld = in_vld;
        e.tag = cur_tag;
        c = b_re; d = b_im; wr = w_re; wi = w_im;
        if (in_cls == 2'b01) begin
            pr = c; pi = d;
        end else if (in_cls == 2'b10) begin
            pr = d; pi = -c;
        end else begin
            pr = rhu(c * wr - d * wi);
            pi = rhu(c * wi + d * wr);
        end
        e.xr = clip16(longint'(a_re) + pr);
        e.xi = clip16(longint'(a_im) + pi);
        e.yr = clip16(longint'(a_re) - pr);
        e.yi = clip16(longint'(a_im) - pi);
        return e;
    endfunction

    always @(posedge clk) begin
        q.push_back(model());
        if (q.size() > 8) void'(q.pop_front());
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (q.size() >= 3 && !done) begin
            exp_t e;
            e = q[q.size() - 3];
            chk(out_vld == e.vld, (e.tag == 1) ? "R1" : "R2", "out_vld",
                int'(out_vld), int'(e.vld));
            if (e.vld || e.tag == 1) begin
                chk(int'(x_re) == e.xr, tname(e.tag), "x_re", int'(x_re), e.xr);
                chk(int'(x_im) == e.xi, tname(e.tag), "x_im", int'(x_im), e.xi);
                chk(int'(y_re) == e.yr, tname(e.tag), "y_re", int'(y_re), e.yr);
                chk(int'(y_im) == e.yi, tname(e.tag), "y_im", int'(y_im), e.yi);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic send(input logic [1:0] cls,
                        input int ar, input int ai, input int br, input int bi,
                        input int wr, input int wi, input int tag);
        @(negedge clk);
        in_vld  = 1'b1;
        in_cls  = cls;
        a_re = 16'(ar); a_im = 16'(ai);
        b_re = 16'(br); b_im = 16'(bi);
        w_re = 16'(wr); w_im = 16'(wi);
        cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_cls = 2'($urandom);
            a_re = 16'($urandom); a_im = 16'($urandom);
            b_re = 16'($urandom); b_im = 16'($urandom);
            w_re = 16'($urandom); w_im = 16'($urandom);
            cur_tag = 2;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_vld = 1'b0; in_cls = 2'b00;
        a_re = 16'sd1234; a_im = -16'sd77; b_re = 16'sd9000; b_im = 16'sd5;
        w_re = 16'sd100; w_im = 16'sd200;
        // R1: inputs active under reset must not reach the outputs
        repeat (3) @(negedge clk);
        in_vld = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R3: general product, half times half
        send(2'b00, 0, 0, 16384, 0, 16384, 0, 3);
        // R3: zero twiddle leaves A
        send(2'b00, 1000, -2000, 32767, -32768, 0, 0, 3);
        // R9: ties round upward
        send(2'b00, 0, 0, 1, 0, 16384, 0, 9);
        send(2'b00, 0, 0, -1, 0, 16384, 0, 9);
        send(2'b00, 0, 0, 3, 0, 16384, 0, 9);
        send(2'b00, 0, 0, 0, -3, 16384, 0, 9);
        // R5: sums clip in both directions
        send(2'b01, 32767, -32768, 32767, -32768, 0, 0, 5);
        send(2'b00, 0, 100, -32768, -32768, -32768, -32768, 5);
        send(2'b00, -32768, -32768, 32767, 32767, 32767, 32767, 5);
        // R6: twiddle one ignores w
        send(2'b01, 10, 20, 300, -400, 12345, -23456, 6);
        send(2'b01, 10, 20, 300, -400, -1, 7, 6);
        // R7: minus-j, including the most negative c
        send(2'b10, 0, 0, -32768, 5, 999, -999, 7);
        send(2'b10, 100, -100, 1234, -4321, 0, 32767, 7);
        // R8: class 11 matches the general path
        send(2'b11, 500, -500, 16384, -8192, 23170, -23170, 8);
        send(2'b00, 500, -500, 16384, -8192, 23170, -23170, 4);
        idle(1);

        // R4 and all classes: random operands with random gaps (R2)
        for (int k = 0; k < 400; k++) begin
            logic [1:0] cls;
            int t;
            cls = 2'($urandom);
            t = (cls == 2'b00) ? 4 : (cls == 2'b01) ? 6 : (cls == 2'b10) ? 7 : 8;
            send(cls, int'(16'($urandom)) - 32768 * 0, 0, 0, 0, 0, 0, t);
            a_re = 16'($urandom); a_im = 16'($urandom);
            b_re = 16'($urandom); b_im = 16'($urandom);
            w_re = 16'($urandom); w_im = 16'($urandom);
            if ($urandom % 4 == 0) idle(1 + ($urandom % 3));
        end
        idle(6);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule